// File: doc/BRIEF.md
# Double-Precision Funnel Shift Unit

This is a combinational 16-bit unit that carries out the double-precision shift operations of an integer datapath. A destination operand and a source operand are joined into one 32-bit funnel. The unit shifts that funnel left or right by a count and returns the 16-bit half that lands in the destination. Bits from the source move into the vacated positions, so a 16-bit word can take its fill from a neighbouring word in one operation.

Alongside the result, the unit produces the complete arithmetic flag set: carry, parity, auxiliary carry, zero, sign and overflow. It also raises a write-enable that tells the write-back stage whether the destination and the flags change. Only the low five bits of the count are used. When those five bits are all zero, the operation has no effect, and the incoming flags and the destination pass through untouched.

Counts from 17 to 31 are longer than one operand. For these counts the funnel wraps the destination back in behind the source. The carry and overflow rules differ between the two directions. Operand fetch and instruction decode sit outside this unit.

Top module: `dbl_shift_unit`

## Requirements
- R1: Only bits [4:0] of `cnt_i` take part (the masked count n); `wr_en_o` is 1 exactly when n is non-zero, and bits [7:5] never change any output.
- R2: When n is 0, `result_o` equals `dst_i` and `flags_o` equals `flags_i`.
- R3: With `dir_right_i`=0 and n in 1..16, `result_o` is the upper 16 bits of {dst_i, src_i} shifted left by n.
- R4: With `dir_right_i`=0 and n in 17..31, `result_o` is (src_i << (n-16)) OR (dst_i >> (32-n)), truncated to 16 bits.
- R5: For a left shift, carry (flags bit 0) is bit (32-n) of {dst_i, src_i}, and overflow (flags bit 5) is carry XOR result bit 15.
- R6: With `dir_right_i`=1 and n in 1..16, `result_o` is the lower 16 bits of {src_i, dst_i} shifted right by n.
- R7: With `dir_right_i`=1 and n in 17..31, `result_o` is (src_i >> (n-16)) OR (dst_i << (32-n)), truncated to 16 bits.
- R8: For a right shift, carry is dst_i bit (n-1) when n is 16 or less and 0 when n is above 16; overflow is result bit 15 XOR result bit 14.
- R9: When n is non-zero, flags bit 3 (zero) is set when the result is 0, bit 4 (sign) is result bit 15, bit 1 (parity) is set when the low 8 result bits hold an even number of ones, and bit 2 (auxiliary carry) is 0.
- R10: When n is exactly 16, `result_o` equals `src_i` in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_right_i | input | 1 | 0 selects the left funnel shift, 1 selects the right funnel shift |
| dst_i | input | 16 | Destination operand; its bits form the kept half of the funnel |
| src_i | input | 16 | Source operand that supplies the fill bits |
| cnt_i | input | 8 | Shift count; only bits [4:0] are used |
| flags_i | input | 6 | Incoming flags {O,S,Z,A,P,C}, bit 0 carry |
| result_o | output | 16 | Shifted destination value |
| flags_o | output | 6 | Outgoing flags, same bit layout as flags_i |
| wr_en_o | output | 1 | High when the result and flags are to be committed |

## Verification
A vector table applies distinctive nibble patterns such as 0x1234/0x5678 in both directions. Because every nibble differs, a shift that is off by one bit or a fill taken from the wrong operand changes a visible digit. The same operands are used at count 4, at the boundary count 16, at count 20 (past one word) and at the extreme count 31. These separate the in-word path from the wrap-around path, and the left carry rule from the right one. A full sweep over all 32 masked counts in both directions, with sparse, dense and alternating operands, is compared against a three-word model. Directed cases then show the following: count values with only upper bits set behave as zero, the all-zero result sets zero and parity, and the right-shift carry reads 0 once the count passes 16.

// File: rtl/dsu_pkg.sv
// Package dsu_pkg
// Shared constants for the double-precision funnel shift unit: the
// positions of each flag inside the flag vector and a parity helper.
// Assumes the flag vector is 6 bits wide with carry in bit 0.
package dsu_pkg;

    localparam int FLAG_W  = 6;
    localparam int FL_CARRY = 0;
    localparam int FL_PAR   = 1;
    localparam int FL_AUX   = 2;
    localparam int FL_ZERO  = 3;
    localparam int FL_SIGN  = 4;
    localparam int FL_OVF   = 5;

    // Number of low result bits that take part in the parity flag.
    localparam int PAR_BITS = 8;

    // Even-parity indicator: 1 when the low PAR_BITS bits hold an even count of ones.
    function automatic logic even_par(input logic [PAR_BITS-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/dsu_left_path.sv
// Module dsu_left_path
// Left funnel shift. It joins {dst, src}, shifts left by n and keeps the
// upper word. For n above W it also folds the destination back in behind
// the source. The carry is the last bit shifted out of the funnel top.
// Assumes n is already masked to $clog2(2*W) bits; the output for n = 0
// is not used by the caller.
module dsu_left_path #(
    parameter int W = 16,
    localparam int FW = 2 * W,
    localparam int NW = $clog2(FW)
) (
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [NW-1:0] n,
    output logic [W-1:0]  res,
    output logic          carry
);

    localparam logic [NW-1:0] W_N = NW'(W);

    logic [FW-1:0] joined;
    logic [FW-1:0] shifted;
    logic [FW-1:0] folded;
    logic [NW-1:0] out_idx;

    // Join the operands and shift the funnel by the masked count.
    always_comb begin
        joined  = {dst, src};
        shifted = joined << n;
        folded  = {{W{1'b0}}, dst} << (n - W_N);
    end

    // Pick the upper word; add the wrapped destination bits for long counts.
    always_comb begin
        if (n > W_N)
            res = shifted[FW-1:W] | folded[FW-1:W];
        else
            res = shifted[FW-1:W];
    end

    // Bit index FW-n, computed modulo FW inside NW bits.
    always_comb begin
        out_idx = NW'(0) - n;
        carry   = joined[out_idx];
    end

endmodule

// File: rtl/dsu_right_path.sv
// Module dsu_right_path
// Right funnel shift. It joins {src, dst}, shifts right by n and keeps the
// lower word. For n above W the destination is wrapped back above the
// source. The carry is destination bit n-1, and reads 0 past the word.
// Assumes n is already masked; the output for n = 0 is not used.
module dsu_right_path #(
    parameter int W = 16,
    localparam int FW = 2 * W,
    localparam int NW = $clog2(FW),
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [NW-1:0] n,
    output logic [W-1:0]  res,
    output logic          carry
);

    localparam logic [NW-1:0] W_N = NW'(W);

    logic [FW-1:0] joined;
    logic [FW-1:0] shifted;
    logic [FW-1:0] folded;
    logic [NW-1:0] wrap_amt;
    logic [NW-1:0] last_idx;

    // Join the operands and shift the funnel right by the masked count.
    always_comb begin
        joined   = {src, dst};
        shifted  = joined >> n;
        wrap_amt = NW'(0) - n;
        folded   = {{W{1'b0}}, dst} << wrap_amt;
    end

    // Pick the lower word; add the wrapped destination bits for long counts.
    always_comb begin
        if (n > W_N)
            res = shifted[W-1:0] | folded[W-1:0];
        else
            res = shifted[W-1:0];
    end

    // Last destination bit shifted out, or 0 once the count passes the word.
    always_comb begin
        last_idx = n - NW'(1);
        if (n <= W_N)
            carry = dst[last_idx[IW-1:0]];
        else
            carry = 1'b0;
    end

endmodule

// File: rtl/dsu_flag_gen.sv
// Module dsu_flag_gen
// Builds the outgoing flag vector. When the operation is live, the flags
// come from the result, the carry and the direction-specific overflow.
// Otherwise the incoming flags pass through unchanged.
// Assumes the flag layout given in dsu_pkg.
module dsu_flag_gen
    import dsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              live,
    input  logic              dir_right,
    input  logic [W-1:0]      res,
    input  logic              carry,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);

    logic ovf;

    // Overflow rule: left uses carry vs top bit, right uses the top two bits.
    always_comb begin
        if (dir_right)
            ovf = res[W-1] ^ res[W-2];
        else
            ovf = carry ^ res[W-1];
    end

    // Assemble fresh flags or hold the incoming ones.
    always_comb begin
        if (live) begin
            flags_out           = '0;
            flags_out[FL_CARRY] = carry;
            flags_out[FL_PAR]   = even_par(res[PAR_BITS-1:0]);
            flags_out[FL_AUX]   = 1'b0;
            flags_out[FL_ZERO]  = (res == '0);
            flags_out[FL_SIGN]  = res[W-1];
            flags_out[FL_OVF]   = ovf;
        end else begin
            flags_out = flags_in;
        end
    end

endmodule

// File: rtl/dbl_shift_unit.sv
// Module dbl_shift_unit
// Top of the double-precision funnel shift unit. It masks the count, runs
// the left and right funnel paths, selects by direction, and produces the
// result, flags and write-enable. It is purely combinational and needs no
// clock or reset. Assumes W is at least PAR_BITS and a power of two.
module dbl_shift_unit
    import dsu_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8,
    localparam int FW   = 2 * W,
    localparam int NW   = $clog2(FW)
) (
    input  logic              dir_right_i,
    input  logic [W-1:0]      dst_i,
    input  logic [W-1:0]      src_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);

    logic [NW-1:0] n;
    logic          live;
    logic [W-1:0]  res_l;
    logic [W-1:0]  res_r;
    logic          cy_l;
    logic          cy_r;
    logic [W-1:0]  res_sel;
    logic          cy_sel;

    // Keep only the low count bits; a zero count makes the operation inert.
    always_comb begin
        n    = cnt_i[NW-1:0];
        live = (n != '0);
    end

    dsu_left_path #(.W(W)) u_left (
        .dst   (dst_i),
        .src   (src_i),
        .n     (n),
        .res   (res_l),
        .carry (cy_l)
    );

    dsu_right_path #(.W(W)) u_right (
        .dst   (dst_i),
        .src   (src_i),
        .n     (n),
        .res   (res_r),
        .carry (cy_r)
    );

    // Select the path named by the direction input.
    always_comb begin
        res_sel = dir_right_i ? res_r : res_l;
        cy_sel  = dir_right_i ? cy_r  : cy_l;
    end

    dsu_flag_gen #(.W(W)) u_flags (
        .live      (live),
        .dir_right (dir_right_i),
        .res       (res_sel),
        .carry     (cy_sel),
        .flags_in  (flags_i),
        .flags_out (flags_o)
    );

    // Drive the outputs; an inert operation returns the destination as-is.
    always_comb begin
        result_o = live ? res_sel : dst_i;
        wr_en_o  = live;
    end

endmodule

// File: rtl/dsu_checker.sv
// Module dsu_checker
// Port-level checks for dbl_shift_unit, attached with bind. The unit is
// combinational, so every check is an immediate assertion evaluated
// whenever the inputs settle. Checks are skipped while any input is unknown.
module dsu_checker
    import dsu_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8
) (
    input logic              dir_right_i,
    input logic [W-1:0]      dst_i,
    input logic [W-1:0]      src_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [W-1:0]      result_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              wr_en_o
);

    localparam int NW = $clog2(2 * W);

    logic known;

    // Gate checks until all inputs carry defined values.
    always_comb begin
        known = !$isunknown({dir_right_i, dst_i, src_i, cnt_i, flags_i});
    end

    // Port relations that must hold for every settled input combination.
    always_comb begin
        if (known) begin
            AST_WE_MASK: assert (wr_en_o == (cnt_i[NW-1:0] != '0)); // R1
            AST_HOLD: assert (wr_en_o || (result_o == dst_i && flags_o == flags_i)); // R2
            AST_OVF_LEFT: assert (!wr_en_o || dir_right_i || flags_o[FL_OVF] == (flags_o[FL_CARRY] ^ result_o[W-1])); // R5
            AST_OVF_RIGHT: assert (!wr_en_o || !dir_right_i || flags_o[FL_OVF] == (result_o[W-1] ^ result_o[W-2])); // R8
            AST_ZERO_SIGN: assert (!wr_en_o || (flags_o[FL_ZERO] == (result_o == '0) && flags_o[FL_SIGN] == result_o[W-1])); // R9
            AST_NO_AUX: assert (!wr_en_o || !flags_o[FL_AUX]); // R9
            AST_FULL_WORD: assert (cnt_i[NW-1:0] != NW'(W) || result_o == src_i); // R10
        end
    end

endmodule

bind dbl_shift_unit dsu_checker #(.W(W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_dbl_shift_unit.sv
`timescale 1ns/1ps
// Bench for dbl_shift_unit: a vector table, a count sweep against a
// three-word model, then directed corner cases.
module sim_dbl_shift_unit;

    logic        clk = 1'b0;
    logic        dir_right;
    logic [15:0] dst, src;
    logic [7:0]  cnt;
    logic [5:0]  fin;
    logic [15:0] res;
    logic [5:0]  fout;
    logic        we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbl_shift_unit u0 (
        .dir_right_i (dir_right),
        .dst_i       (dst),
        .src_i       (src),
        .cnt_i       (cnt),
        .flags_i     (fin),
        .result_o    (res),
        .flags_o     (fout),
        .wr_en_o     (we)
    );

    // Fields: dir, cnt, dst, src, flags_in, exp result, exp flags, exp we (70 bits)
    localparam int NV = 14;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 8'd4,    16'h1234, 16'h5678, 6'h00, 16'h2345, 6'h21, 1'b1}, // R3 R5
        {1'b1, 8'd4,    16'h1234, 16'h5678, 6'h00, 16'h8123, 6'h30, 1'b1}, // R6 R8
        {1'b0, 8'd16,   16'h8001, 16'hABCD, 6'h00, 16'hABCD, 6'h11, 1'b1}, // R10 R5
        {1'b1, 8'd16,   16'h8001, 16'hABCD, 6'h00, 16'hABCD, 6'h31, 1'b1}, // R10 R8
        {1'b0, 8'd20,   16'h1234, 16'h5678, 6'h00, 16'h6781, 6'h23, 1'b1}, // R4
        {1'b1, 8'd20,   16'h1234, 16'h5678, 6'h00, 16'h4567, 6'h20, 1'b1}, // R7
        {1'b0, 8'd31,   16'h8000, 16'h0001, 6'h00, 16'hC000, 6'h32, 1'b1}, // R4
        {1'b0, 8'h20,   16'hBEEF, 16'h1111, 6'h2A, 16'hBEEF, 6'h2A, 1'b0}, // R1 R2
        {1'b1, 8'h00,   16'h0F0F, 16'hFFFF, 6'h15, 16'h0F0F, 6'h15, 1'b0}, // R2
        {1'b0, 8'd1,    16'h0000, 16'h0000, 6'h3F, 16'h0000, 6'h0A, 1'b1}, // R9
        {1'b1, 8'd1,    16'h0001, 16'h0000, 6'h00, 16'h0000, 6'h0B, 1'b1}, // R9 R8
        {1'b0, 8'hE4,   16'h1234, 16'h5678, 6'h00, 16'h2345, 6'h21, 1'b1}, // R1
        {1'b1, 8'd17,   16'hFFFF, 16'h0000, 6'h01, 16'h8000, 6'h32, 1'b1}, // R8 R7
        {1'b1, 8'hE0,   16'h7777, 16'h0000, 6'h3F, 16'h7777, 6'h3F, 1'b0}  // R1 R2
    };

    // Three-word model: {dst,src,dst} shifted, then the right word taken.
    function automatic logic [15:0] mdl_res(input bit right, input logic [15:0] d,
                                            input logic [15:0] s, input int n);
        logic [47:0] x;
        x = {d, s, d};
        if (n == 0) return d;
        if (right) begin
            x = x >> n;
            return x[15:0];
        end
        x = x << n;
        return x[47:32];
    endfunction

    function automatic logic [5:0] mdl_flags(input bit right, input logic [15:0] d,
                                             input logic [15:0] s, input int n,
                                             input logic [5:0] fi);
        logic [15:0] r;
        logic [31:0] j;
        logic c, o;
        int ones;
        if (n == 0) return fi;
        r = mdl_res(right, d, s, n);
        j = {d, s};
        if (right) begin
            c = (n <= 16) ? d[n-1] : 1'b0;
            o = r[15] ^ r[14];
        end else begin
            c = j[32-n];
            o = c ^ r[15];
        end
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(r[k]);
        return {o, r[15], (r == 16'h0), 1'b0, (ones % 2 == 0), c};
    endfunction

    task automatic apply(input bit d_r, input logic [7:0] c, input logic [15:0] d,
                         input logic [15:0] s, input logic [5:0] f);
        @(negedge clk);
        dir_right = d_r;
        cnt = c;
        dst = d;
        src = s;
        fin = f;
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] er, input logic [5:0] ef,
                         input logic ew);
        checks++;
        if (res !== er || fout !== ef || we !== ew) begin
            fails++;
            $display("FAIL %s: dir=%0d cnt=%0d got res=%h flags=%h we=%b exp res=%h flags=%h we=%b",
                     tag, dir_right, cnt, res, fout, we, er, ef, ew);
        end
    endtask

    initial begin
        logic [15:0] pa [3];
        pa[0] = 16'h0001; pa[1] = 16'hFFFF; pa[2] = 16'hA55A;

        // Inert state before any operation: zero count holds everything (R2).
        apply(1'b0, 8'h00, 16'h0000, 16'h0000, 6'h00);
        check("R2 idle", 16'h0000, 6'h00, 1'b0);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            v = VEC[i];
            apply(v[69], v[68:61], v[60:45], v[44:29], v[28:23]);
            check($sformatf("R3-vector %0d (R1..R10 table)", i), v[22:7], v[6:1], v[0]);
        end

        // Sweep every masked count in both directions against the model.
        for (int p = 0; p < 3; p++) begin
            for (int dr = 0; dr < 2; dr++) begin
                for (int n = 0; n < 32; n++) begin
                    string tag;
                    logic [15:0] d, s;
                    d = pa[p];
                    s = ~pa[(p + 1) % 3];
                    if (n == 0) tag = "R2";
                    else if (dr == 0) tag = (n <= 16) ? "R3 R5 R9" : "R4 R5 R9";
                    else tag = (n <= 16) ? "R6 R8 R9" : "R7 R8 R9";
                    apply(dr[0], 8'(n) | 8'h60, d, s, 6'h2D);
                    check($sformatf("%s sweep", tag), mdl_res(dr[0], d, s, n),
                          mdl_flags(dr[0], d, s, n, 6'h2D), n != 0);
                end
            end
        end

        // Directed: upper count bits ignored, equal to the masked count (R1).
        apply(1'b1, 8'hA7, 16'hC3A5, 16'h1E0F, 6'h00);
        check("R1 upper count bits", mdl_res(1'b1, 16'hC3A5, 16'h1E0F, 7),
              mdl_flags(1'b1, 16'hC3A5, 16'h1E0F, 7, 6'h00), 1'b1);
        // Directed: right carry reads 0 just past the word even with dst all ones (R8).
        apply(1'b1, 8'd18, 16'hFFFF, 16'hFFFF, 6'h01);
        check("R8 carry past word", 16'hFFFF, 6'h12, 1'b1);
        // Directed: left count 16 passes source, carry is dst bit 0 (R10).
        apply(1'b0, 8'd16, 16'h0000, 16'h8000, 6'h00);
        check("R10 left full word", 16'h8000, 6'h32, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule